// File: doc/BRIEF.md
# Vector Select-Compare and Merge Unit

This block performs lane-wise comparisons across an eight-lane vector of signed 16-bit elements. For each lane it picks one of the two operands as the result. Four select compares (less-than, equal, not-equal, greater-or-equal) write one outcome bit per lane into a 16-bit compare-code register. They also pass through the lane the operand chosen by that outcome. A merge op reuses the stored code bits to choose between the operands. A clip compare fills both halves of the code register, each half with a different lane relation.

Select compares also take the borrow and not-equal flags left behind by an earlier borrow-producing subtract. This lets a pair of compares finish a double-precision comparison: the upper words decide, and the lower-word outcome breaks ties. After such a compare the unit asks the flag owner to clear those flags. Every operation is issued with a one-cycle valid strobe, and its effects appear on the registered outputs one clock later.

Top module: `vsc_unit`

## Requirements
- R1: After synchronous reset, out_code, out_res, out_valid and out_flag_clr are all zero.
- R2: A legal operation issued with in_valid high sets out_valid high on the next clock only. The result and the code register change on that same clock. Cycles without in_valid leave out_res and out_code unchanged and keep out_valid low.
- R3: Opcode encoding on in_op: 0 less-than, 1 equal, 2 not-equal, 3 greater-or-equal, 4 merge, 5 clip. Codes 6 and 7 are ignored: out_valid stays low and out_code and out_res keep their values.
- R4: Less-than treats lanes as signed and is true in lane i when vs < vt. It is also true when vs == vt and both flag bits of that lane are set. in_flags bit i is the borrow flag of lane i and bit 8+i is its not-equal flag. Lane i occupies bits 16i+15 down to 16i of each vector.
- R5: Equal is true in lane i when vs == vt and the lane's not-equal flag is clear. Not-equal is its exact complement.
- R6: Greater-or-equal is the exact complement of less-than, including the flag-based tie rule.
- R7: A select compare writes each lane outcome to code bit i, clears code bits 8 to 15, and outputs vs in lanes where the outcome is true and vt elsewhere.
- R8: out_flag_clr pulses high for one cycle, together with out_valid, after each select compare. It stays low after merge, clip and ignored opcodes.
- R9: Merge outputs vs in lanes whose code bit i is 1 and vt in the others. It leaves all 16 code bits unchanged.
- R10: Clip sets code bit i when vs >= vt and code bit 8+i when vs <= -vt. The negation is exact, so -(-32768) is +32768. The result takes vt where vs >= vt and vs elsewhere.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Operation strobe |
| in_op | input | 3 | Opcode |
| in_vs | input | 128 | First operand vector, eight 16-bit lanes |
| in_vt | input | 128 | Second operand vector, eight 16-bit lanes |
| in_flags | input | 16 | Borrow flags (low half) and not-equal flags (high half) |
| out_valid | output | 1 | Result valid, one clock after a legal strobe |
| out_res | output | 128 | Selected result vector |
| out_code | output | 16 | Compare-code register |
| out_flag_clr | output | 1 | Request to clear the borrow/not-equal flags |

## Verification
The bench builds the unit with its default eight lanes of 16 bits. At that size the signed extremes can be driven directly: 0x8000 against 0x7FFF, and clip against -32768, where exact negation matters. Lane patterns place each flag combination (borrow only, not-equal only, both) against equal operands in distinct lanes. Running merge right after compare and clip ops shows that merge reads the stored code bits and that select compares clear the upper half.

// File: rtl/vsc_pkg.sv
package vsc_pkg;

    localparam int DEF_LANES = 8;
    localparam int DEF_WIDTH = 16;

    typedef enum logic [2:0] {
        OP_LT   = 3'd0,
        OP_EQ   = 3'd1,
        OP_NE   = 3'd2,
        OP_GE   = 3'd3,
        OP_MRG  = 3'd4,
        OP_CLIP = 3'd5
    } vsc_op_e;

    // Decoded control for one operation
    typedef struct packed {
        logic legal;
        logic sel;
        logic mrg;
        logic clip;
        logic use_eq;
        logic invert;
    } vsc_ctrl_t;

    // Per-lane relations computed from the operands and flags
    typedef struct packed {
        logic lt_x;   // less-than including flag tie rule
        logic eq_x;   // equal qualified by not-equal flag
        logic ge_c;   // vs >= vt
        logic le_n;   // vs <= -vt
    } vsc_rel_t;

    function automatic vsc_ctrl_t vsc_decode(input logic [2:0] op);
        vsc_ctrl_t c;
        c = '0;
        case (op)
            OP_LT:   begin c.legal = 1'b1; c.sel = 1'b1; end
            OP_GE:   begin c.legal = 1'b1; c.sel = 1'b1; c.invert = 1'b1; end
            OP_EQ:   begin c.legal = 1'b1; c.sel = 1'b1; c.use_eq = 1'b1; end
            OP_NE:   begin c.legal = 1'b1; c.sel = 1'b1; c.use_eq = 1'b1; c.invert = 1'b1; end
            OP_MRG:  begin c.legal = 1'b1; c.mrg = 1'b1; end
            OP_CLIP: begin c.legal = 1'b1; c.clip = 1'b1; end
            default: c = '0;
        endcase
        return c;
    endfunction

endpackage

// File: rtl/vsc_op_ctrl.sv
module vsc_op_ctrl
    import vsc_pkg::*;
(
    input  logic [2:0] op,
    output vsc_ctrl_t  ctrl
);
    always_comb begin
        ctrl = vsc_decode(op);
    end
endmodule

// File: rtl/vsc_lane_cmp.sv
module vsc_lane_cmp
    import vsc_pkg::*;
#(
    parameter int W = DEF_WIDTH
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    input  logic         borrow,
    input  logic         ne,
    output vsc_rel_t     rel
);
    // One extra bit so the negation of the most negative value is exact
    logic signed [W:0] a_x;
    logic signed [W:0] b_x;
    logic signed [W:0] nb_x;
    logic              same;

    always_comb begin
        a_x  = {a[W-1], a};
        b_x  = {b[W-1], b};
        nb_x = -b_x;
        same = (a == b);
        rel.lt_x = (a_x < b_x) | (same & borrow & ne);
        rel.eq_x = same & ~ne;
        rel.ge_c = (a_x >= b_x);
        rel.le_n = (a_x <= nb_x);
    end
endmodule

// File: rtl/vsc_lane_sel.sv
module vsc_lane_sel
    import vsc_pkg::*;
#(
    parameter int W = DEF_WIDTH
) (
    input  vsc_ctrl_t    ctrl,
    input  vsc_rel_t     rel,
    input  logic [W-1:0] vs,
    input  logic [W-1:0] vt,
    input  logic         code_lo,
    input  logic         code_hi,
    output logic [W-1:0] res,
    output logic         lo,
    output logic         hi
);
    logic cond;

    always_comb begin
        cond = ctrl.invert ^ (ctrl.use_eq ? rel.eq_x : rel.lt_x);
        res  = vt;
        lo   = code_lo;
        hi   = code_hi;
        if (ctrl.sel) begin
            res = cond ? vs : vt;
            lo  = cond;
            hi  = 1'b0;
        end else if (ctrl.mrg) begin
            res = code_lo ? vs : vt;
        end else if (ctrl.clip) begin
            res = rel.ge_c ? vt : vs;
            lo  = rel.ge_c;
            hi  = rel.le_n;
        end
    end
endmodule

// File: rtl/vsc_unit.sv
module vsc_unit
    import vsc_pkg::*;
#(
    parameter int LANES = DEF_LANES,
    parameter int W     = DEF_WIDTH
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 in_valid,
    input  logic [2:0]           in_op,
    input  logic [LANES*W-1:0]   in_vs,
    input  logic [LANES*W-1:0]   in_vt,
    input  logic [2*LANES-1:0]   in_flags,
    output logic                 out_valid,
    output logic [LANES*W-1:0]   out_res,
    output logic [2*LANES-1:0]   out_code,
    output logic                 out_flag_clr
);
    localparam int VW = LANES * W;
    localparam int CW = 2 * LANES;

    vsc_ctrl_t         ctrl;
    vsc_rel_t          rel [LANES];
    logic [VW-1:0]     res_n;
    logic [CW-1:0]     code_n;
    logic [VW-1:0]     res_q;
    logic [CW-1:0]     code_q;
    logic              vld_q;
    logic              clr_q;
    logic              fire;

    vsc_op_ctrl u_ctrl (
        .op   (in_op),
        .ctrl (ctrl)
    );

    for (genvar i = 0; i < LANES; i++) begin : g_lane
        vsc_lane_cmp #(.W(W)) u_cmp (
            .a      (in_vs[i*W +: W]),
            .b      (in_vt[i*W +: W]),
            .borrow (in_flags[i]),
            .ne     (in_flags[LANES+i]),
            .rel    (rel[i])
        );
        vsc_lane_sel #(.W(W)) u_sel (
            .ctrl    (ctrl),
            .rel     (rel[i]),
            .vs      (in_vs[i*W +: W]),
            .vt      (in_vt[i*W +: W]),
            .code_lo (code_q[i]),
            .code_hi (code_q[LANES+i]),
            .res     (res_n[i*W +: W]),
            .lo      (code_n[i]),
            .hi      (code_n[LANES+i])
        );
    end

    assign fire = in_valid & ctrl.legal;

    always_ff @(posedge clk) begin
        if (rst) begin
            res_q  <= '0;
            code_q <= '0;
            vld_q  <= 1'b0;
            clr_q  <= 1'b0;
        end else begin
            vld_q <= fire;
            clr_q <= fire & ctrl.sel;
            if (fire) begin
                res_q  <= res_n;
                code_q <= code_n;
            end
        end
    end

    assign out_valid    = vld_q;
    assign out_res      = res_q;
    assign out_code     = code_q;
    assign out_flag_clr = clr_q;
endmodule

// File: rtl/vsc_unit_chk.sv
module vsc_unit_chk #(
    parameter int LANES = 8,
    parameter int W     = 16
) (
    input logic               clk,
    input logic               rst,
    input logic               in_valid,
    input logic [2:0]         in_op,
    input logic               out_valid,
    input logic [LANES*W-1:0] out_res,
    input logic [2*LANES-1:0] out_code,
    input logic               out_flag_clr
);
    // R8
    clr_with_valid_chk: assert property (@(posedge clk) disable iff (rst)
        out_flag_clr |-> out_valid);

    // R8
    clr_only_select_chk: assert property (@(posedge clk) disable iff (rst)
        out_flag_clr |-> ($past(in_valid) && ($past(in_op) < 3'd4)));

    // R7
    sel_hi_clear_chk: assert property (@(posedge clk) disable iff (rst)
        out_flag_clr |-> (out_code[2*LANES-1:LANES] == '0));

    // R9
    merge_keeps_code_chk: assert property (@(posedge clk) disable iff (rst)
        ($past(in_valid) && ($past(in_op) == 3'd4)) |-> $stable(out_code));

    // R2
    idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !$past(in_valid) |-> ($stable(out_code) && $stable(out_res) && !out_valid));

    // R3
    illegal_ignored_chk: assert property (@(posedge clk) disable iff (rst)
        ($past(in_valid) && ($past(in_op) > 3'd5)) |-> (!out_valid && $stable(out_code) && $stable(out_res)));
endmodule

bind vsc_unit vsc_unit_chk #(.LANES(LANES), .W(W)) u_chk (
    .clk          (clk),
    .rst          (rst),
    .in_valid     (in_valid),
    .in_op        (in_op),
    .out_valid    (out_valid),
    .out_res      (out_res),
    .out_code     (out_code),
    .out_flag_clr (out_flag_clr)
);

// File: tb/vsc_unit_test.sv
module vsc_unit_test;
    localparam int L  = 8;
    localparam int W  = 16;
    localparam int VW = L * W;
    localparam int CW = 2 * L;

    logic          clk = 1'b0;
    logic          rst;
    logic          in_valid;
    logic [2:0]    in_op;
    logic [VW-1:0] in_vs;
    logic [VW-1:0] in_vt;
    logic [CW-1:0] in_flags;
    logic          out_valid;
    logic [VW-1:0] out_res;
    logic [CW-1:0] out_code;
    logic          out_flag_clr;

    int n_chk  = 0;
    int n_fail = 0;
    logic          finished = 1'b0;
    logic [CW-1:0] m_code;
    logic [VW-1:0] m_res;

    always #10 clk = ~clk;

    vsc_unit uut (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_op(in_op),
        .in_vs(in_vs), .in_vt(in_vt), .in_flags(in_flags),
        .out_valid(out_valid), .out_res(out_res), .out_code(out_code),
        .out_flag_clr(out_flag_clr)
    );

    task automatic chk(input string tag, input logic [VW-1:0] act, input logic [VW-1:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Reference from the requirements: one lane at a time, integer math
    task automatic model(input logic [2:0] op, input logic [VW-1:0] vs,
                         input logic [VW-1:0] vt, input logic [CW-1:0] fl);
        logic [CW-1:0] nc;
        logic [VW-1:0] nr;
        nc = m_code;
        nr = m_res;
        if (op <= 3'd5) begin
            for (int i = 0; i < L; i++) begin
                int  s;
                int  t;
                logic lt, eq, c;
                s  = int'($signed(vs[i*W +: W]));
                t  = int'($signed(vt[i*W +: W]));
                lt = (s < t) || (s == t && fl[i] && fl[L+i]);
                eq = (s == t) && !fl[L+i];
                case (op)
                    3'd0: c = lt;
                    3'd1: c = eq;
                    3'd2: c = !eq;
                    default: c = !lt;
                endcase
                if (op <= 3'd3) begin
                    nc[i] = c; nc[L+i] = 1'b0;
                    nr[i*W +: W] = c ? vs[i*W +: W] : vt[i*W +: W];
                end else if (op == 3'd4) begin
                    nr[i*W +: W] = m_code[i] ? vs[i*W +: W] : vt[i*W +: W];
                end else begin
                    nc[i] = (s >= t); nc[L+i] = (s <= -t);
                    nr[i*W +: W] = (s >= t) ? vt[i*W +: W] : vs[i*W +: W];
                end
            end
        end
        m_code = nc;
        m_res  = nr;
    endtask

    task automatic run_op(input string tag, input logic [2:0] op, input logic [VW-1:0] vs,
                          input logic [VW-1:0] vt, input logic [CW-1:0] fl);
        logic legal;
        legal = (op <= 3'd5);
        @(negedge clk);
        in_valid = 1'b1; in_op = op; in_vs = vs; in_vt = vt; in_flags = fl;
        model(op, vs, vt, fl);
        @(negedge clk);
        in_valid = 1'b0;
        chk({tag, " R2 out_valid"}, VW'(out_valid), VW'(legal));
        chk({tag, " result"}, out_res, m_res);
        chk({tag, " code"}, VW'(out_code), VW'(m_code));
        chk({tag, " R8 flag_clr"}, VW'(out_flag_clr), VW'(op <= 3'd3));
        @(negedge clk);
        chk({tag, " R2 valid pulse ends"}, VW'(out_valid), '0);
        chk({tag, " R8 flag_clr pulse ends"}, VW'(out_flag_clr), '0);
    endtask

    task automatic test_reset();
        rst = 1'b1; in_valid = 1'b0; in_op = '0; in_vs = '0; in_vt = '0; in_flags = '0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        m_code = '0; m_res = '0;
        chk("R1 code", VW'(out_code), '0);
        chk("R1 result", out_res, '0);
        chk("R1 valid", VW'(out_valid), '0);
        chk("R1 flag_clr", VW'(out_flag_clr), '0);
    endtask

    localparam logic [VW-1:0] LT_VS = 128'h0005_0005_FFFF_8000_7FFF_0003_0003_0003;
    localparam logic [VW-1:0] LT_VT = 128'h0005_0005_0001_7FFF_8000_0003_0003_0004;

    task automatic test_lt();
        run_op("R4 lt flags", 3'd0, LT_VS, LT_VT, 16'h8206);
        // true lanes 0,1,4,5 by hand
        chk("R4 lt hand code", VW'(out_code), VW'(16'h0033));
        run_op("R4 lt noflags", 3'd0, LT_VS, LT_VT, 16'h0000);
        chk("R4 lt hand code noflags", VW'(out_code), VW'(16'h0031));
    endtask

    task automatic test_eq_ne();
        run_op("R5 eq", 3'd1, LT_VS, LT_VT, 16'h8206);
        // equal lanes 1,2,6,7; ne flag on 1,7 -> true 2,6
        chk("R5 eq hand code", VW'(out_code), VW'(16'h0044));
        run_op("R5 ne", 3'd2, LT_VS, LT_VT, 16'h8206);
        chk("R5 ne hand code", VW'(out_code), VW'(16'h00BB));
    endtask

    task automatic test_ge();
        run_op("R6 ge", 3'd3, LT_VS, LT_VT, 16'h8206);
        chk("R6 ge hand code", VW'(out_code), VW'(16'h00CC));
    endtask

    localparam logic [VW-1:0] CL_VS = 128'h0000_0005_8000_0000_FFFB_0003_8001_7FFF;
    localparam logic [VW-1:0] CL_VT = 128'h0000_0004_8000_8000_0005_0003_7FFF_7FFF;

    task automatic test_clip();
        run_op("R10 clip", 3'd5, CL_VS, CL_VT, 16'h00FF);
        // lane0 32767 vs 32767: ge=1 le=0; lane1 -32767 vs 32767: ge=0 le=1
        // lane2 3,3: ge=1 le=0; lane3 -5,5: ge=0 le=1; lane4 0,-32768: ge=1 le=1
        // lane5 -32768,-32768: ge=1 le=1; lane6 5,4: ge=1 le=0; lane7 0,0: ge=1 le=1
        chk("R10 clip hand code", VW'(out_code), VW'(16'hBA_F5));
    endtask

    task automatic test_select_clears_hi();
        run_op("R7 select after clip", 3'd0, CL_VS, CL_VT, 16'h0000);
        chk("R7 upper half cleared", VW'(out_code[CW-1:L]), '0);
    endtask

    task automatic test_merge();
        run_op("R9 set code", 3'd0, LT_VS, LT_VT, 16'h8206);
        run_op("R9 merge", 3'd4, 128'h1111_2222_3333_4444_5555_6666_7777_8888,
               128'hAAAA_BBBB_CCCC_DDDD_EEEE_FFFF_0101_0202, 16'hFFFF);
        chk("R9 merge hand result", out_res, 128'hAAAA_BBBB_3333_4444_EEEE_FFFF_7777_8888);
        chk("R9 merge hand code", VW'(out_code), VW'(16'h0033));
        run_op("R9 clip then merge prep", 3'd5, CL_VS, CL_VT, 16'h0000);
        run_op("R9 merge after clip", 3'd4, CL_VT, CL_VS, 16'h0000);
    endtask

    task automatic test_illegal();
        logic [VW-1:0] r0;
        logic [CW-1:0] c0;
        r0 = out_res; c0 = out_code;
        run_op("R3 op6", 3'd6, LT_VS, LT_VT, 16'hFFFF);
        chk("R3 op6 result held", out_res, r0);
        chk("R3 op6 code held", VW'(out_code), VW'(c0));
        run_op("R3 op7", 3'd7, CL_VS, CL_VT, 16'h0000);
        chk("R3 op7 code held", VW'(out_code), VW'(c0));
    endtask

    task automatic test_hold();
        logic [VW-1:0] r0;
        logic [CW-1:0] c0;
        run_op("R2 prep", 3'd3, LT_VS, LT_VT, 16'h0000);
        r0 = out_res; c0 = out_code;
        in_vs = ~LT_VS; in_vt = ~LT_VT; in_op = 3'd5;
        repeat (4) @(negedge clk);
        chk("R2 idle result held", out_res, r0);
        chk("R2 idle code held", VW'(out_code), VW'(c0));
        chk("R2 idle valid low", VW'(out_valid), '0);
    endtask

    initial begin
        test_reset();
        test_lt();
        test_eq_ne();
        test_ge();
        test_clip();
        test_select_clears_hi();
        test_merge();
        test_illegal();
        test_hold();
        finished = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end
endmodule